// File: doc/BRIEF.md
# Two-wire register slave with address pointer

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). A host uses it to reach a small bank of byte-wide registers that sit outside the block, behind a plain register-file port. The host first names a register by writing a pointer byte. It can then write one data byte in the same transaction, or it can read the selected byte back in a separate read transaction.

The 7-bit slave address has a fixed upper part. Its two low bits come from a three-level strap. An external level detector presents the strap state as a 2-bit code, and the block captures it only while reset is held. One register index is reserved as an intrusion-clear location. A write to that index also pulses a clear output, which resets an intrusion flag held outside the block.

The bus lines are oversampled on the system clock through a synchroniser chain. Clock edges, START and STOP are all detected on the synchronised samples, and the data line is driven by an output enable that pulls it low.

Top module: `tw_regslave`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe`, `rf_we` and `intr_clr` are 0 and `rf_addr` is 0.
- R2: The slave address is `{ADDR_HI, A1, A0}`, with ADDR_HI = 01011 by default. The strap code on `strap_lvl` maps as follows: 00 (grounded) gives A1A0 = 10, 01 (floating) gives 00, 10 (tied high) gives 01, and 11 is treated as floating.
- R3: `strap_lvl` is captured only while reset is asserted. Changing it after reset leaves the address that is answered unchanged.
- R4: After a START the block shifts in 8 bits, MSB first: the address, then R/W (1 = read). On a match it pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and makes no response until the next START.
- R5: In a write, the first byte after the address is loaded into the pointer, which drives `rf_addr`, and the byte is acknowledged.
- R6: A second write byte is acknowledged and produces one single-cycle `rf_we` pulse, with `rf_addr` equal to the pointer and `rf_wdata` equal to the byte.
- R7: A third or later write byte is not acknowledged and causes no write.
- R8: In a read, the block sends the byte on `rf_rdata` that it captured when it acknowledged the address. The byte goes out MSB first, and SDA is released after the eighth bit.
- R9: A repeated START in the middle of a transfer abandons that transfer, with no write issued, and restarts address reception.
- R10: A write whose pointer equals CLR_REG raises `intr_clr` for exactly the cycle in which `rf_we` is high.
- R11: After a STOP the block ignores bus clocking until a new START. An address byte clocked without a START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is captured while low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_lvl | input | 2 | Strap level code: 00 ground, 01 floating, 10 supply |
| rf_we | output | 1 | Register write strobe, one cycle |
| rf_addr | output | PTR_W (8) | Pointer value, used as the register index |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Combinational read data for `rf_addr` |
| intr_clr | output | 1 | Intrusion-flag clear pulse |

## Verification
The bench builds the block with SYNC_STAGES = 3, PTR_W = 8, HAS_CLR = 1 and CLR_REG = 0x1F. The deeper synchroniser stretches the delay from a bus edge to the response, so each quarter bit period of 8 system clocks still has to cover it. The full 8-bit pointer lets the bench reach both a preloaded register and written registers across the whole index range. With the clear variant built in, the intrusion-clear pulse can be checked against the write strobe. The bench also resets the block once for each strap code, which exercises all three address variants and the hold of the strap after reset.

// File: rtl/tw_pkg.sv
package tw_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_WRX,
      ST_RD,
      ST_RACK,
      ST_SKIP
   } tw_state_e;

   typedef enum logic [1:0] {
      STRAP_GND  = 2'b00,
      STRAP_OPEN = 2'b01,
      STRAP_VCC  = 2'b10,
      STRAP_RSVD = 2'b11
   } strap_e;

   function automatic logic [1:0] strap_to_low(input logic [1:0] lvl);
      case (strap_e'(lvl))
         STRAP_GND: return 2'b10;
         STRAP_VCC: return 2'b01;
         default:   return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES:0] scl_chain;
   logic [STAGES:0] sda_chain;
   logic            scl_q;
   logic            sda_q;

   assign scl_chain[0] = scl_i;
   assign sda_chain[0] = sda_i;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_chain[g+1] <= 1'b1;
            sda_chain[g+1] <= 1'b1;
         end else begin
            scl_chain[g+1] <= scl_chain[g];
            sda_chain[g+1] <= sda_chain[g];
         end
      end
   end

   assign scl_s = scl_chain[STAGES];
   assign sda_s = sda_chain[STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tw_addr_strap.sv
module tw_addr_strap #(
   parameter logic [4:0] ADDR_HI = 5'b01011
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_lvl,
   output logic [6:0] dev_addr
);
   import tw_pkg::*;

   logic [1:0] low_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) low_bits <= strap_to_low(strap_lvl);
   end

   assign dev_addr = {ADDR_HI, low_bits};

   // R3
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(low_bits));

endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm #(
   parameter int          PTR_W   = 8,
   parameter int unsigned CLR_REG = 32'h1F,
   parameter bit          HAS_CLR = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_s,
   input  logic                      sda_s,
   input  logic                      scl_rise,
   input  logic                      scl_fall,
   input  logic                      start_det,
   input  logic                      stop_det,
   input  logic [6:0]                dev_addr,
   output logic                      sda_oe,
   output logic                      rf_we,
   output logic [PTR_W-1:0]          rf_addr,
   output logic [tw_pkg::BYTE_W-1:0] rf_wdata,
   input  logic [tw_pkg::BYTE_W-1:0] rf_rdata,
   output logic                      intr_clr
);
   import tw_pkg::*;

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [PTR_W-1:0] CLR_IDX  = CLR_REG[PTR_W-1:0];

   tw_state_e          st;
   logic [CNT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  rx_sh;
   logic [BYTE_W-1:0]  tx_sh;
   logic               rw_q;
   logic [1:0]         byte_idx;
   logic [PTR_W-1:0]   ptr_q;
   logic [BYTE_W-1:0]  wdata_q;
   logic               we_q;
   logic               oe_q;
   logic               byte_end;
   logic               wr_hit;

   assign byte_end = scl_fall && (bit_cnt == LAST_BIT) && !start_det && !stop_det;
   assign wr_hit   = (st == ST_WRX) && byte_end && (byte_idx == 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rw_q     <= 1'b0;
         byte_idx <= '0;
         ptr_q    <= '0;
         wdata_q  <= '0;
         we_q     <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (start_det) begin
            st      <= ST_ADDR;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else if (stop_det) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_end) begin
                     if (rx_sh[7:1] == dev_addr) begin
                        st       <= ST_ACK;
                        oe_q     <= 1'b1;
                        rw_q     <= rx_sh[0];
                        byte_idx <= '0;
                        if (rx_sh[0]) tx_sh <= rf_rdata;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rw_q) begin
                        st   <= ST_RD;
                        oe_q <= ~tx_sh[BYTE_W-1];
                     end else begin
                        st   <= ST_WRX;
                        oe_q <= 1'b0;
                     end
                  end
               end
               ST_WRX: begin
                  if (scl_rise) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_end) begin
                     case (byte_idx)
                        2'd0: begin
                           ptr_q    <= rx_sh[PTR_W-1:0];
                           oe_q     <= 1'b1;
                           st       <= ST_ACK;
                           byte_idx <= 2'd1;
                        end
                        2'd1: begin
                           we_q     <= 1'b1;
                           wdata_q  <= rx_sh;
                           oe_q     <= 1'b1;
                           st       <= ST_ACK;
                           byte_idx <= 2'd2;
                        end
                        default: st <= ST_SKIP;
                     endcase
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        oe_q <= 1'b0;
                        st   <= ST_RACK;
                     end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                        oe_q  <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) st <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign rf_we    = we_q;
   assign rf_addr  = ptr_q;
   assign rf_wdata = wdata_q;

   if (HAS_CLR) begin : g_clr
      logic clr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clr_q <= 1'b0;
         else        clr_q <= wr_hit && (ptr_q == CLR_IDX);
      end
      assign intr_clr = clr_q;
   end else begin : g_no_clr
      assign intr_clr = 1'b0;
   end

   // R6
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R5
   ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rf_addr) |-> $past(scl_fall));

   // R4
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R10
   clr_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intr_clr |-> rf_we);

endmodule

// File: rtl/tw_regslave.sv
module tw_regslave #(
   parameter int          SYNC_STAGES = 2,
   parameter int          PTR_W       = 8,
   parameter logic [4:0]  ADDR_HI     = 5'b01011,
   parameter int unsigned CLR_REG     = 32'h1F,
   parameter bit          HAS_CLR     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [1:0]       strap_lvl,
   output logic             rf_we,
   output logic [PTR_W-1:0] rf_addr,
   output logic [7:0]       rf_wdata,
   input  logic [7:0]       rf_rdata,
   output logic             intr_clr
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
      $error("PTR_W must lie between 1 and 8");
   end
   if (HAS_CLR && (CLR_REG >= (32'd1 << PTR_W))) begin : g_bad_clr
      $error("CLR_REG does not fit in PTR_W bits");
   end

   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic [6:0] dev_addr;

   tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   tw_addr_strap #(.ADDR_HI(ADDR_HI)) u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_lvl (strap_lvl),
      .dev_addr  (dev_addr)
   );

   tw_proto_fsm #(
      .PTR_W   (PTR_W),
      .CLR_REG (CLR_REG),
      .HAS_CLR (HAS_CLR)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .dev_addr  (dev_addr),
      .sda_oe    (sda_oe),
      .rf_we     (rf_we),
      .rf_addr   (rf_addr),
      .rf_wdata  (rf_wdata),
      .rf_rdata  (rf_rdata),
      .intr_clr  (intr_clr)
   );

endmodule

// File: tb/tw_regslave_tb_top.sv
module tw_regslave_tb_top;

   localparam int       Q   = 8;
   localparam logic [7:0] CLR = 8'h1F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b01;
   logic       sda_oe, rf_we, intr_clr;
   logic [7:0] rf_addr, rf_wdata, rf_rdata;
   logic       sda_line;
   logic [7:0] mem [256];

   typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   int n_chk = 0;
   int n_fail = 0;
   int clr_seen = 0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   tw_regslave #(
      .SYNC_STAGES (3),
      .PTR_W       (8),
      .CLR_REG     (32'h1F),
      .HAS_CLR     (1'b1)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .strap_lvl (strap),
      .rf_we     (rf_we),
      .rf_addr   (rf_addr),
      .rf_wdata  (rf_wdata),
      .rf_rdata  (rf_rdata),
      .intr_clr  (intr_clr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected writes and compares
   always @(negedge clk) begin
      if (rst_n && rf_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected write", int'(rf_addr), 0);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(rf_addr == e.a, "R6 write address", int'(rf_addr), int'(e.a));
            chk(rf_wdata == e.d, "R6 write data", int'(rf_wdata), int'(e.d));
            chk(intr_clr == (e.a == CLR), "R10 clear with write", int'(intr_clr), int'(e.a == CLR));
         end
         if (intr_clr) clr_seen++;
         mem[rf_addr] = rf_wdata;
      end else if (rst_n && intr_clr) begin
         chk(1'b0, "R10 clear without write", 1, 0);
      end
   end

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic t_start();
      sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
   endtask

   task automatic t_stop();
      sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(1);
   endtask

   task automatic t_bit(input logic b);
      sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
   endtask

   task automatic t_wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) t_bit(b[i]);
      sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
      ack = sda_line; wq(1); scl_m = 1'b0; wq(1);
   endtask

   task automatic t_rbyte(output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1); scl_m = 1'b1; wq(1); v[i] = sda_line; wq(1); scl_m = 1'b0;
      end
      wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
   endtask

   task automatic do_reset(input logic [1:0] s);
      rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic set_ptr(input logic [7:0] dev, input logic [7:0] p, input string tag);
      logic a;
      t_start();
      t_wbyte({dev[6:0], 1'b0}, a); chk(a == 1'b0, {tag, " address ack"}, a, 0);
      t_wbyte(p, a);                chk(a == 1'b0, {tag, " pointer ack"}, a, 0);
      t_stop();
   endtask

   task automatic rd_reg(input logic [7:0] dev, input logic [7:0] exp, input string tag);
      logic a;
      logic [7:0] v;
      t_start();
      t_wbyte({dev[6:0], 1'b1}, a); chk(a == 1'b0, {tag, " read address ack"}, a, 0);
      t_rbyte(v);
      chk(v == exp, {tag, " read data"}, v, exp);
      chk(sda_oe == 1'b0, "R8 released after byte", sda_oe, 0);
      t_stop();
   endtask

   task automatic probe(input logic [7:0] dev, input logic exp_ack, input string tag);
      logic a;
      t_start();
      t_wbyte({dev[6:0], 1'b0}, a);
      chk(a == exp_ack, tag, a, exp_ack);
      t_stop();
   endtask

   initial begin
      logic a;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      do_reset(2'b01);

      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(rf_we == 1'b0, "R1 rf_we", rf_we, 0);
      chk(rf_addr == 8'h00, "R1 rf_addr", rf_addr, 0);
      chk(intr_clr == 1'b0, "R1 intr_clr", intr_clr, 0);

      // R4 R5 pointer only
      set_ptr(8'h2C, 8'h10, "R5");
      chk(rf_addr == 8'h10, "R5 pointer loaded", rf_addr, 8'h10);

      // R6 pointer and data
      exp_q.push_back('{a: 8'h21, d: 8'hA5});
      t_start();
      t_wbyte(8'h58, a); chk(a == 1'b0, "R6 address ack", a, 0);
      t_wbyte(8'h21, a); chk(a == 1'b0, "R6 pointer ack", a, 0);
      t_wbyte(8'hA5, a); chk(a == 1'b0, "R6 data ack", a, 0);
      t_stop();
      chk(exp_q.size() == 0, "R6 write seen", exp_q.size(), 0);

      // R8 reads
      set_ptr(8'h2C, 8'h21, "R8");
      rd_reg(8'h2C, 8'hA5, "R8");
      set_ptr(8'h2C, 8'h33, "R8");
      rd_reg(8'h2C, 8'h69, "R8");

      // R7 extra byte ignored
      exp_q.push_back('{a: 8'h40, d: 8'h3C});
      t_start();
      t_wbyte(8'h58, a);
      t_wbyte(8'h40, a);
      t_wbyte(8'h3C, a); chk(a == 1'b0, "R6 data ack", a, 0);
      t_wbyte(8'h77, a); chk(a == 1'b1, "R7 third byte nack", a, 1);
      t_stop();
      chk(exp_q.size() == 0, "R7 only one write", exp_q.size(), 0);
      set_ptr(8'h2C, 8'h40, "R7");
      rd_reg(8'h2C, 8'h3C, "R7");

      // R10 intrusion clear
      exp_q.push_back('{a: CLR, d: 8'h00});
      t_start();
      t_wbyte(8'h58, a); t_wbyte(CLR, a); t_wbyte(8'h00, a);
      t_stop();
      chk(clr_seen == 1, "R10 clear pulse count", clr_seen, 1);

      // R9 repeated start mid-byte
      set_ptr(8'h2C, 8'h21, "R9");
      t_start();
      t_wbyte(8'h58, a); t_wbyte(8'h21, a);
      t_bit(1'b1); t_bit(1'b0); t_bit(1'b1); t_bit(1'b1);
      t_start();
      t_wbyte(8'h59, a); chk(a == 1'b0, "R9 restart address ack", a, 0);
      begin
         logic [7:0] v;
         t_rbyte(v);
         chk(v == 8'hA5, "R9 read after restart", v, 8'hA5);
      end
      t_stop();
      chk(exp_q.size() == 0, "R9 no write", exp_q.size(), 0);

      // R4 mismatch
      t_start();
      t_wbyte(8'h5A, a); chk(a == 1'b1, "R4 foreign address nack", a, 1);
      t_wbyte(8'h00, a); chk(a == 1'b1, "R4 idle after mismatch", a, 1);
      t_stop();
      chk(rf_addr == 8'h21, "R4 pointer untouched", rf_addr, 8'h21);

      // R11 no response without START
      scl_m = 1'b0; wq(1);
      t_wbyte(8'h58, a); chk(a == 1'b1, "R11 no start no ack", a, 1);
      t_stop();

      // R2 strap decode
      do_reset(2'b00);
      probe(8'h2E, 1'b0, "R2 ground ack");
      probe(8'h2C, 1'b1, "R2 ground other nack");
      do_reset(2'b10);
      probe(8'h2D, 1'b0, "R2 supply ack");
      do_reset(2'b11);
      probe(8'h2C, 1'b0, "R2 code 11 as floating");

      // R3 strap frozen after reset
      do_reset(2'b01);
      strap = 2'b10;
      wq(2);
      probe(8'h2D, 1'b1, "R3 new strap ignored");
      probe(8'h2C, 1'b0, "R3 old address kept");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule